// File: doc/BRIEF.md
# Receive Address Filter and Status Queue

This block decides, frame by frame, whether an incoming frame is kept. It looks at the six destination address bytes and weighs them against a programmed station address and a four-bit filter setting. A small state machine walks each frame through three states. `CL_IDLE` waits for a frame. `CL_ADDR` collects the address bytes. `CL_DONE` holds the verdict until the frame ends. The machine takes these transitions:

- *start*: any state goes to `CL_ADDR` on `frame_start`.
- *classify*: `CL_ADDR` goes to `CL_DONE` on the sixth address byte.
- *abort*: `CL_ADDR` goes to `CL_IDLE` on `frame_end` if fewer than six bytes have arrived.
- *complete*: `CL_DONE` goes to `CL_IDLE` on `frame_end`.

When an accepted frame completes, its byte count and error cause go into a queue of four entries. The receive status word at the ports always shows the oldest queued frame. A `discard` pulse removes that frame, and the next frame's word then appears. Rejected frames and aborted frames leave no entry. A completion that arrives while the queue is full is dropped, and it raises a sticky overrun flag.

The driving logic first writes the station address, one byte per index. It then holds the filter setting steady, and reads and discards status words as frames complete.

Top module: `rx_filter_status`

## Requirements
- R1: After reset, `status_word` is 16'h8000, `verdict_valid` is 0 and `overrun` is 0.
- R2: With filter bit 0 set, a frame whose six destination bytes equal station bytes 0..5, received in that order, is accepted.
- R3: With filter bit 1 set, a multicast frame is accepted. A frame is multicast when bit 0 of its first destination byte is 1 and the address is not all ones. Under bit 1 alone, an all-ones address is rejected.
- R4: With filter bit 2 set, a destination of all ones (broadcast) is accepted.
- R5: With filter bit 3 set, every frame is accepted, whatever its address.
- R6: A frame that no set filter bit admits is rejected, and it adds no entry to the queue. A filter of 0 rejects everything.
- R7: A queued status word has bit 15 = 0 and bit 14 = the error flag. Bits 13:11 hold the error cause (0 overrun, 1 oversize, 2 dribble, 3 runt, 4 alignment, 5 CRC), forced to 0 when the error flag is clear. Bits 10:0 hold the byte count.
- R8: While the queue is empty, `status_word` reads 16'h8000.
- R9: Status words come out in completion order. A `discard` pulse removes the head, and the next word is visible one cycle later.
- R10: The queue holds 4 words. A completion while it is full is dropped, the 4 held words are kept, and `overrun` goes to 1 and stays there until reset.
- R11: A `discard` pulse while the queue is empty has no effect.
- R12: A `frame_end` before the sixth address byte drops the frame. A `frame_start` in the middle of a frame restarts classification.
- R13: `verdict_valid` goes high for exactly one cycle, in the cycle after the sixth address byte, and `verdict_accept` then carries the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sta_wr | input | 1 | Write strobe for one station address byte |
| sta_idx | input | 3 | Station byte index, 0..5 (first byte received is 0) |
| sta_data | input | 8 | Station byte value |
| filter_mode | input | 4 | Bit 0 own, bit 1 multicast, bit 2 broadcast, bit 3 all |
| frame_start | input | 1 | Pulse: a new frame begins |
| addr_valid | input | 1 | A destination address byte is on `addr_byte` |
| addr_byte | input | 8 | Destination address byte |
| frame_end | input | 1 | Pulse: the frame is complete |
| frame_err | input | 1 | Frame has an error (sampled with `frame_end`) |
| err_code | input | 3 | Error cause (sampled with `frame_end`) |
| byte_count | input | 11 | Received byte count (sampled with `frame_end`) |
| discard | input | 1 | Pulse: remove the head status word |
| verdict_valid | output | 1 | One-cycle pulse: the verdict is ready |
| verdict_accept | output | 1 | Verdict: 1 means accepted |
| status_word | output | 16 | Status word of the head frame |
| overrun | output | 1 | Sticky: a completion was dropped because the queue was full |

## Verification
A classifier stuck in the wrong state, or with a stale byte index, shows up as a wrong or missing `verdict_valid` pulse one cycle after the sixth address byte. The same fault later shows up as a status word that never appears. Queue pointer or count faults show up at the next `discard`: a word comes out repeated, skipped or out of order, or bit 15 is set while frames are still pending. The overflow and empty-pop cases each fail on the first word read after the event.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        CL_IDLE = 2'd0,
        CL_ADDR = 2'd1,
        CL_DONE = 2'd2
    } cls_state_t;

    localparam int CNT_W  = 11;
    localparam int CODE_W = 3;
    localparam int ENTRY_W = 1 + CODE_W + CNT_W;

    function automatic logic [ENTRY_W-1:0] pack_entry(
        input logic              err,
        input logic [CODE_W-1:0] code,
        input logic [CNT_W-1:0]  cnt
    );
        return {err, (err ? code : {CODE_W{1'b0}}), cnt};
    endfunction
endpackage

// File: rtl/rxf_classifier.sv
module rxf_classifier
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_BYTES*8-1:0] station,
    input  logic [3:0]              filter,
    input  logic                    frame_start,
    input  logic                    addr_valid,
    input  logic [7:0]              addr_byte,
    input  logic                    frame_end,
    output logic                    verdict_valid,
    output logic                    verdict_accept,
    output logic                    push_req
);
    localparam int IW = $clog2(ADDR_BYTES + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(ADDR_BYTES - 1);

    cls_state_t    state, state_n;
    logic [IW-1:0] idx;
    logic          own_hit, all_ones, grp_bit;
    logic          own_n, ones_n, grp_n, mcast_n, accept_n;
    logic          take_byte, last_byte;

    assign take_byte = (state == CL_ADDR) && addr_valid && !frame_start && !frame_end;
    assign last_byte = take_byte && (idx == LAST_IDX);

    always_comb begin
        own_n    = own_hit && (addr_byte == station[int'(idx)*8 +: 8]);
        ones_n   = all_ones && (addr_byte == 8'hFF);
        grp_n    = (idx == '0) ? addr_byte[0] : grp_bit;
        mcast_n  = grp_n && !ones_n;
        accept_n = filter[3] || (filter[0] && own_n) ||
                   (filter[1] && mcast_n) || (filter[2] && ones_n);
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            CL_IDLE: if (frame_start) state_n = CL_ADDR;
            CL_ADDR: begin
                if (frame_start)    state_n = CL_ADDR;
                else if (frame_end) state_n = CL_IDLE;
                else if (last_byte) state_n = CL_DONE;
            end
            CL_DONE: begin
                if (frame_start)    state_n = CL_ADDR;
                else if (frame_end) state_n = CL_IDLE;
            end
            default: state_n = CL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CL_IDLE;
        else        state <= state_n;
    end

    // address accumulation and verdict outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx            <= '0;
            own_hit        <= 1'b1;
            all_ones       <= 1'b1;
            grp_bit        <= 1'b0;
            verdict_valid  <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_valid <= last_byte;
            if (frame_start) begin
                idx      <= '0;
                own_hit  <= 1'b1;
                all_ones <= 1'b1;
                grp_bit  <= 1'b0;
            end else if (take_byte) begin
                idx      <= idx + 1'b1;
                own_hit  <= own_n;
                all_ones <= ones_n;
                grp_bit  <= grp_n;
            end
            if (last_byte) verdict_accept <= accept_n;
        end
    end

    assign push_req = (state == CL_DONE) && frame_end && !frame_start && verdict_accept;

    // R13: verdict pulse lasts one cycle
    p_verdict_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);
    // R13: verdict follows entry into the done state
    p_verdict_state_r13: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> (state == CL_DONE) || (state == CL_ADDR) || (state == CL_IDLE && $past(frame_end)));
    // R6: only accepted frames are pushed
    p_push_accepted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> verdict_accept);
endmodule

// File: rtl/rxf_status_queue.sv
module rxf_status_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         overrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic [CW-1:0] count;
    logic          full, do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CFULL);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            wptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == PMAX) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PMAX) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && !do_push) overrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // R10: occupancy never exceeds the depth
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CFULL);
    // R10: a push into a full queue without a pop keeps the occupancy
    p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)) && overrun);
    // R10: overrun is sticky
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R11: popping an empty queue changes nothing
    p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty && $stable(rptr));
endmodule

// File: rtl/rx_filter_status.sv
module rx_filter_status
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int QUEUE_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sta_wr,
    input  logic [2:0]  sta_idx,
    input  logic [7:0]  sta_data,
    input  logic [3:0]  filter_mode,
    input  logic        frame_start,
    input  logic        addr_valid,
    input  logic [7:0]  addr_byte,
    input  logic        frame_end,
    input  logic        frame_err,
    input  logic [2:0]  err_code,
    input  logic [10:0] byte_count,
    input  logic        discard,
    output logic        verdict_valid,
    output logic        verdict_accept,
    output logic [15:0] status_word,
    output logic        overrun
);
    logic [ADDR_BYTES*8-1:0] station;
    logic                    push_req, q_empty;
    logic [ENTRY_W-1:0]      q_head;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta
        always_ff @(posedge clk) begin
            if (!rst_n)                                  station[g*8 +: 8] <= 8'h00;
            else if (sta_wr && (int'(sta_idx) == g))     station[g*8 +: 8] <= sta_data;
        end
    end

    rxf_classifier #(.ADDR_BYTES(ADDR_BYTES)) u_cls (
        .clk            (clk),
        .rst_n          (rst_n),
        .station        (station),
        .filter         (filter_mode),
        .frame_start    (frame_start),
        .addr_valid     (addr_valid),
        .addr_byte      (addr_byte),
        .frame_end      (frame_end),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept),
        .push_req       (push_req)
    );

    rxf_status_queue #(.DEPTH(QUEUE_DEPTH), .W(ENTRY_W)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .push_data (pack_entry(frame_err, err_code, byte_count)),
        .pop       (discard),
        .head      (q_head),
        .empty     (q_empty),
        .overrun   (overrun)
    );

    assign status_word = q_empty ? 16'h8000 : {1'b0, q_head};

    // R8/R7: bit 15 set only as the fixed empty word
    p_empty_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[15] |-> (status_word[14:0] == '0));
    // R9: a push into an empty queue makes the word visible next cycle
    p_push_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && q_empty) |=> !status_word[15]);
endmodule

// File: tb/rx_filter_status_test.sv
module rx_filter_status_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sta_wr = 1'b0;
    logic [2:0]  sta_idx = '0;
    logic [7:0]  sta_data = '0;
    logic [3:0]  filter_mode = '0;
    logic        frame_start = 1'b0;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        frame_end = 1'b0;
    logic        frame_err = 1'b0;
    logic [2:0]  err_code = '0;
    logic [10:0] byte_count = '0;
    logic        discard = 1'b0;
    logic        verdict_valid, verdict_accept, overrun;
    logic [15:0] status_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] sb[$];
    logic [47:0] station = 48'h55_44_33_22_11_02; // byte 0 = 8'h02

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_filter_status uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    function automatic bit exp_accept(input logic [47:0] da, input logic [3:0] f);
        bit own = (da == station);
        bit bc  = (da == 48'hFFFF_FFFF_FFFF);
        bit mc  = da[0] && !bc;
        return f[3] || (f[0] && own) || (f[1] && mc) || (f[2] && bc);
    endfunction

    task automatic send_frame(input logic [47:0] da, input logic err, input logic [2:0] code,
                              input logic [10:0] cnt, input string req);
        bit acc = exp_accept(da, filter_mode);
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            addr_valid = 1'b1; addr_byte = da[i*8 +: 8];
            @(negedge clk);
        end
        addr_valid = 1'b0;
        check(verdict_valid === 1'b1 && verdict_accept === acc, req,
              {verdict_valid, verdict_accept}, {1'b1, acc});
        @(negedge clk);
        check(verdict_valid === 1'b0, {req, "/R13"}, verdict_valid, 0);
        frame_end = 1'b1; frame_err = err; err_code = code; byte_count = cnt;
        @(negedge clk);
        frame_end = 1'b0; frame_err = 1'b0;
        if (acc) sb.push_back({1'b0, err, (err ? code : 3'd0), cnt});
    endtask

    task automatic drain_one(input string req);
        logic [15:0] e = sb.pop_front();
        check(status_word === e, req, status_word, e);
        discard = 1'b1;
        @(negedge clk);
        discard = 1'b0;
    endtask

    task automatic expect_empty(input string req);
        check(status_word === 16'h8000, req, status_word, 16'h8000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(status_word === 16'h8000 && verdict_valid === 1'b0 && overrun === 1'b0, "R1",
              {status_word, verdict_valid, overrun}, {16'h8000, 2'b00});
        for (int i = 0; i < 6; i++) begin
            sta_wr = 1'b1; sta_idx = 3'(i); sta_data = station[i*8 +: 8];
            @(negedge clk);
        end
        sta_wr = 1'b0;

        // R2 own address
        filter_mode = 4'b0001;
        send_frame(station, 1'b0, 3'd0, 11'd64, "R2 own accept");
        drain_one("R2 word");
        send_frame(48'h66_44_33_22_11_02, 1'b0, 3'd0, 11'd70, "R6 other unicast reject");
        expect_empty("R6 not queued");
        // R3 multicast
        filter_mode = 4'b0010;
        send_frame(48'h01_00_00_5E_00_01, 1'b1, 3'd5, 11'd100, "R3 multicast accept");
        drain_one("R7 crc word");
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0, 3'd0, 11'd60, "R3 broadcast not multicast");
        expect_empty("R3 not queued");
        // R4 broadcast
        filter_mode = 4'b0100;
        send_frame(48'hFFFF_FFFF_FFFF, 1'b1, 3'd3, 11'd20, "R4 broadcast accept");
        send_frame(station, 1'b0, 3'd0, 11'd90, "R4 own rejected");
        drain_one("R7 runt word");
        expect_empty("R8 empty after drain");
        // R5 promiscuous
        filter_mode = 4'b1000;
        send_frame(48'h12_34_56_78_9A_BC, 1'b0, 3'd6, 11'd1514, "R5 any accept");
        drain_one("R7 code masked when no error");
        // R6 filter zero
        filter_mode = 4'b0000;
        send_frame(48'hFFFF_FFFF_FFFF, 1'b0, 3'd0, 11'd64, "R6 zero filter");
        expect_empty("R6 empty");

        // R10 overflow, R9 order
        filter_mode = 4'b1000;
        send_frame(48'h1, 1'b0, 3'd0, 11'd101, "R10 f1");
        send_frame(48'h2, 1'b1, 3'd1, 11'd1515, "R10 f2");
        send_frame(48'h3, 1'b1, 3'd2, 11'd103, "R10 f3");
        send_frame(48'h4, 1'b1, 3'd4, 11'd104, "R10 f4");
        check(overrun === 1'b0, "R10 no overrun at depth", overrun, 0);
        send_frame(48'h5, 1'b0, 3'd0, 11'd105, "R10 f5");
        void'(sb.pop_back()); // dropped
        check(overrun === 1'b1, "R10 overrun set", overrun, 1);
        for (int i = 0; i < 4; i++) drain_one("R9 order");
        expect_empty("R8 empty after overflow drain");
        check(overrun === 1'b1, "R10 overrun sticky", overrun, 1);

        // R11 discard on empty
        discard = 1'b1; @(negedge clk); discard = 1'b0;
        expect_empty("R11 still empty");
        send_frame(48'h7, 1'b0, 3'd0, 11'd77, "R11 after empty pop");
        drain_one("R11 single entry");
        expect_empty("R11 no phantom entry");

        // R12 short frame and restart
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            addr_valid = 1'b1; addr_byte = 8'hAA; @(negedge clk);
        end
        addr_valid = 1'b0;
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        @(negedge clk);
        check(verdict_valid === 1'b0, "R12 no verdict", verdict_valid, 0);
        expect_empty("R12 short frame dropped");
        filter_mode = 4'b0001;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            addr_valid = 1'b1; addr_byte = 8'hEE; @(negedge clk);
        end
        addr_valid = 1'b0;
        send_frame(station, 1'b0, 3'd0, 11'd42, "R12 restart own accept");
        drain_one("R12 restarted word");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule